// File: doc/BRIEF.md
# DMA Control-Byte Write Decoder

This block is the byte-wide programming port of a two-port DMA controller. Software writes a stream of bytes to one port address. The first byte of each group is classified by its bit pattern. It is either a base register write or a one-byte command. A base byte can announce follow-on parameter bytes. Their destination codes are placed in an ordered pending queue, and each later write is steered to the register at the head of that queue. One of those follow-on bytes, the interrupt-control byte, can itself append further destinations to the queue.

The commands load the port counters from the programmed addresses, continue a stopped transfer, switch enable and interrupt enable, force the ready level, clear status, and control the read-back sequence. The transfer engine is outside this block. It reports byte, stall, match and end-of-block events on four inputs and uses the programmed values that this block presents.

Top module: `dmaw_ctrl`

## Requirements
- R1: Every accepted write clears `dma_en`. After the write, `dma_en` is 1 only when that same byte is a register-3 byte with bit 6 set, command 0x87 or command 0xD3.
- R2: With the queue empty, a byte with bit 7 = 0 and bits 1:0 ≠ 00 is register 0 and is stored in `reg0_q`. Its bits 3, 4, 5 and 6 queue, in that order, port A address low, port A address high, block length low and block length high.
- R3: With the queue empty, a byte with bit 7 = 0 and bits 1:0 = 00 is a timing byte. It goes to `timing_a` when bit 2 = 1 and to `timing_b` when bit 2 = 0. Its bit 6 queues one byte that is dropped and has no effect, apart from the R1 enable clear.
- R4: A byte with bit 7 = 1 and bits 1:0 = 00 is register 3. Bit 3 queues a mask byte and bit 4 queues a match byte, in that order. Bit 5 is loaded into `int_en` and bit 6 into `dma_en`.
- R5: A byte with bit 7 = 1, bits 1:0 = 01 and bits 6:5 ≠ 11 is register 4. Bits 6:5 become `mode`. Bits 2, 3 and 4 queue port B address low, port B address high and an interrupt-control byte, in that order. When bits 6:5 = 11 the byte is ignored.
- R6: An interrupt-control byte is stored in `int_ctl`. Its bit 3 appends a pulse byte and then its bit 4 appends a vector byte, both behind any entries still pending.
- R7: A byte with bit 7 = 1, bits 1:0 = 10 and bits 6 and 2 both 0 is stored in `reg5_q`. Any other byte with bits 1:0 = 10 and bit 7 = 1 is ignored.
- R8: A byte with bit 7 = 1 and bits 1:0 = 11 is a command selected by bits 6:2. The codes are: 0x87 enables and clears the pending increment; 0xAB sets `int_en`; 0xAF clears `int_en`; 0xB3 copies `reg5_q` bit 3 into `ready_lvl`. Codes 0x83, 0xC7 and 0xCB do nothing beyond R1.
- R9: The event inputs `ev_match` and `ev_end` set `match_flg` and `end_flg`. Command 0x8B clears both flags, and a command in the same cycle takes priority over an event.
- R10: Command 0xC3 clears `reg0_q` bits 1:0, the pending-increment state and `int_en`.
- R11: Command 0xCF copies `addr_a` into `cnt_a` and `addr_b` into `cnt_b`, zeroes `byte_cnt` and clears both flags.
- R12: Command 0xD3 works as follows. If an increment is pending (set by `ev_stall`), each port counter steps by its timing byte bits 5:4: 00 decrements, 01 increments and 1x holds. The pending flag is then cleared. The command also clears both flags, zeroes `byte_cnt` and sets `dma_en`.
- R13: Command 0xBB queues a read-mask byte. When that byte arrives it is stored in `rd_mask`. Command 0xBF sets `rd_mask` to 0x01. Command 0xA7 leaves the mask unchanged. All three cases raise `rd_restart` for the one cycle after the write.
- R14: The queue keeps up to 8 destinations in first-in order. A synchronous `rst` empties it and returns every output to 0, except `ready_lvl`, which resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Written byte |
| ev_byte | input | 1 | Engine moved one byte (byte counter +1) |
| ev_stall | input | 1 | Engine stopped mid-transfer (increment pending) |
| ev_match | input | 1 | Engine found a match |
| ev_end | input | 1 | Engine reached end of block |
| addr_a | output | 16 | Programmed port A address |
| addr_b | output | 16 | Programmed port B address |
| blk_len | output | 16 | Programmed block length |
| cnt_a | output | 16 | Port A counter |
| cnt_b | output | 16 | Port B counter |
| byte_cnt | output | 16 | Transferred-byte counter |
| timing_a | output | 8 | Port A timing byte |
| timing_b | output | 8 | Port B timing byte |
| reg0_q | output | 8 | Last register-0 byte |
| reg5_q | output | 8 | Last register-5 byte |
| int_ctl | output | 8 | Interrupt-control byte |
| pulse_q | output | 8 | Pulse byte |
| vector_q | output | 8 | Vector byte |
| mask_q | output | 8 | Mask byte |
| match_q | output | 8 | Match byte |
| rd_mask | output | 8 | Read-back selection mask |
| mode | output | 2 | Transfer mode |
| dma_en | output | 1 | DMA enable |
| int_en | output | 1 | Interrupt enable |
| ready_lvl | output | 1 | Ready state |
| match_flg | output | 1 | Match status flag |
| end_flg | output | 1 | End-of-block status flag |
| rd_restart | output | 1 | One-cycle read-sequence restart |

## Verification
The assertions check on every cycle that:
- the queue is never popped empty and never overfilled;
- each write drops enable unless the byte itself re-enables;
- reset, load, continue and status-clear commands leave their targets in the stated state on the next cycle.

Only the bench scenarios can show the following:
- follow-on bytes land in the announced order, including the appended pulse and vector bytes;
- dropped and ignored bytes change nothing;
- a pending increment steps each counter in the direction its timing byte selects.

An exhaustive sweep of all 256 first bytes checks the enable, interrupt-enable and mode outcome of the classification.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

  typedef enum logic [3:0] {
    D_A_LO, D_A_HI, D_LEN_LO, D_LEN_HI, D_DROP, D_MASK, D_MATCH,
    D_B_LO, D_B_HI, D_ICTL, D_PULSE, D_VEC, D_RDMASK
  } dest_t;

  typedef enum logic [2:0] {
    K_NONE, K_R0, K_TIM, K_R3, K_R4, K_R5, K_CMD
  } kind_t;

  localparam int PUSHW = 4;

  localparam logic [4:0] C_NOP   = 5'd0;
  localparam logic [4:0] C_EN    = 5'd1;
  localparam logic [4:0] C_CLRST = 5'd2;
  localparam logic [4:0] C_RDSEQ = 5'd9;
  localparam logic [4:0] C_IEN   = 5'd10;
  localparam logic [4:0] C_IDIS  = 5'd11;
  localparam logic [4:0] C_FRDY  = 5'd12;
  localparam logic [4:0] C_RDMSK = 5'd14;
  localparam logic [4:0] C_RDST  = 5'd15;
  localparam logic [4:0] C_RST   = 5'd16;
  localparam logic [4:0] C_LOAD  = 5'd19;
  localparam logic [4:0] C_CONT  = 5'd20;

  // Counter step selected by timing bits 5:4: 00 down, 01 up, 1x hold.
  function automatic logic [15:0] step_ctr(input logic [15:0] c, input logic [7:0] tim);
    case (tim[5:4])
      2'b00:   return c - 16'd1;
      2'b01:   return c + 16'd1;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
(
  input  logic [7:0] b,
  output kind_t      kind,
  output logic [4:0] cmd,
  output dest_t      codes [PUSHW],
  output logic [2:0] n
);

  assign cmd = b[6:2];

  always_comb begin
    kind = K_NONE;
    if (!b[7]) begin
      kind = (b[1:0] != 2'b00) ? K_R0 : K_TIM;
    end else begin
      case (b[1:0])
        2'b00: kind = K_R3;
        2'b01: if (b[6:5] != 2'b11) kind = K_R4;
        2'b10: if (!b[6] && !b[2]) kind = K_R5;
        default: kind = K_CMD;
      endcase
    end
  end

  always_comb begin
    n = 3'd0;
    for (int i = 0; i < PUSHW; i++) codes[i] = D_DROP;
    case (kind)
      K_R0: begin
        if (b[3]) begin codes[n[1:0]] = D_A_LO;   n = n + 3'd1; end
        if (b[4]) begin codes[n[1:0]] = D_A_HI;   n = n + 3'd1; end
        if (b[5]) begin codes[n[1:0]] = D_LEN_LO; n = n + 3'd1; end
        if (b[6]) begin codes[n[1:0]] = D_LEN_HI; n = n + 3'd1; end
      end
      K_TIM: if (b[6]) begin codes[0] = D_DROP; n = 3'd1; end
      K_R3: begin
        if (b[3]) begin codes[n[1:0]] = D_MASK;  n = n + 3'd1; end
        if (b[4]) begin codes[n[1:0]] = D_MATCH; n = n + 3'd1; end
      end
      K_R4: begin
        if (b[2]) begin codes[n[1:0]] = D_B_LO; n = n + 3'd1; end
        if (b[3]) begin codes[n[1:0]] = D_B_HI; n = n + 3'd1; end
        if (b[4]) begin codes[n[1:0]] = D_ICTL; n = n + 3'd1; end
      end
      K_CMD: if (cmd == C_RDMSK) begin codes[0] = D_RDMASK; n = 3'd1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/dmaw_queue.sv
module dmaw_queue
  import dmaw_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pop,
  input  logic [2:0] push_n,
  input  dest_t      push_codes [PUSHW],
  output dest_t      head,
  output logic       empty
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dest_t         q   [DEPTH];
  dest_t         nq  [DEPTH];
  logic [CW-1:0] cnt, nc;

  always_comb begin
    int idx;
    nq = q;
    nc = cnt;
    if (pop && cnt != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) nq[i] = q[i + 1];
      nc = cnt - CW'(1);
    end
    for (int i = 0; i < PUSHW; i++) begin
      idx = int'(nc) + i;
      if (i < int'(push_n) && idx < DEPTH) nq[idx[IW-1:0]] = push_codes[i];
    end
    nc = nc + CW'(push_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= D_DROP;
    end else begin
      cnt <= nc;
      q   <= nq;
    end
  end

  assign head  = q[0];
  assign empty = (cnt == '0);

  a_r14_pop_only_when_held: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);
  a_r14_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_n != 3'd0) |-> (int'(cnt) - int'(pop) + int'(push_n) <= DEPTH));

endmodule

// File: rtl/dmaw_ctrl.sv
module dmaw_ctrl
  import dmaw_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        ev_byte,
  input  logic        ev_stall,
  input  logic        ev_match,
  input  logic        ev_end,
  output logic [15:0] addr_a,
  output logic [15:0] addr_b,
  output logic [15:0] blk_len,
  output logic [15:0] cnt_a,
  output logic [15:0] cnt_b,
  output logic [15:0] byte_cnt,
  output logic [7:0]  timing_a,
  output logic [7:0]  timing_b,
  output logic [7:0]  reg0_q,
  output logic [7:0]  reg5_q,
  output logic [7:0]  int_ctl,
  output logic [7:0]  pulse_q,
  output logic [7:0]  vector_q,
  output logic [7:0]  mask_q,
  output logic [7:0]  match_q,
  output logic [7:0]  rd_mask,
  output logic [1:0]  mode,
  output logic        dma_en,
  output logic        int_en,
  output logic        ready_lvl,
  output logic        match_flg,
  output logic        end_flg,
  output logic        rd_restart
);

  kind_t      kind;
  logic [4:0] cmd;
  dest_t      dcodes [PUSHW];
  logic [2:0] dn;
  dest_t      pcodes [PUSHW];
  logic [2:0] pn;
  dest_t      head;
  logic       q_empty;
  logic       pend_inc;

  dmaw_decode u_dec (.b(wr_data), .kind(kind), .cmd(cmd), .codes(dcodes), .n(dn));

  // Named events for the assertions.
  wire follow  = wr_en && !q_empty;
  wire base    = wr_en && q_empty;
  wire is_cmd  = base && kind == K_CMD;
  wire c_en    = is_cmd && cmd == C_EN;
  wire c_clrst = is_cmd && cmd == C_CLRST;
  wire c_rst   = is_cmd && cmd == C_RST;
  wire c_load  = is_cmd && cmd == C_LOAD;
  wire c_cont  = is_cmd && cmd == C_CONT;
  wire r3_en   = base && kind == K_R3 && wr_data[6];

  always_comb begin
    for (int i = 0; i < PUSHW; i++) pcodes[i] = D_DROP;
    pn = 3'd0;
    if (base) begin
      pcodes = dcodes;
      pn     = dn;
    end else if (follow && head == D_ICTL) begin
      if (wr_data[3]) begin pcodes[pn[1:0]] = D_PULSE; pn = pn + 3'd1; end
      if (wr_data[4]) begin pcodes[pn[1:0]] = D_VEC;   pn = pn + 3'd1; end
    end
  end

  dmaw_queue #(.DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .pop(follow), .push_n(pn), .push_codes(pcodes),
    .head(head), .empty(q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_a <= '0; addr_b <= '0; blk_len <= '0;
      cnt_a <= '0; cnt_b <= '0; byte_cnt <= '0;
      timing_a <= '0; timing_b <= '0; reg0_q <= '0; reg5_q <= '0;
      int_ctl <= '0; pulse_q <= '0; vector_q <= '0; mask_q <= '0; match_q <= '0;
      rd_mask <= '0; mode <= '0; dma_en <= 1'b0; int_en <= 1'b0;
      ready_lvl <= 1'b1; match_flg <= 1'b0; end_flg <= 1'b0;
      rd_restart <= 1'b0; pend_inc <= 1'b0;
    end else begin
      rd_restart <= 1'b0;
      if (ev_byte)  byte_cnt  <= byte_cnt + 16'd1;
      if (ev_stall) pend_inc  <= 1'b1;
      if (ev_match) match_flg <= 1'b1;
      if (ev_end)   end_flg   <= 1'b1;
      if (wr_en)    dma_en    <= 1'b0;

      if (follow) begin
        case (head)
          D_A_LO:   addr_a[7:0]   <= wr_data;
          D_A_HI:   addr_a[15:8]  <= wr_data;
          D_LEN_LO: blk_len[7:0]  <= wr_data;
          D_LEN_HI: blk_len[15:8] <= wr_data;
          D_B_LO:   addr_b[7:0]   <= wr_data;
          D_B_HI:   addr_b[15:8]  <= wr_data;
          D_MASK:   mask_q        <= wr_data;
          D_MATCH:  match_q       <= wr_data;
          D_ICTL:   int_ctl       <= wr_data;
          D_PULSE:  pulse_q       <= wr_data;
          D_VEC:    vector_q      <= wr_data;
          D_RDMASK: begin rd_mask <= wr_data; rd_restart <= 1'b1; end
          default: ;
        endcase
      end

      if (base) begin
        case (kind)
          K_R0:  reg0_q <= wr_data;
          K_TIM: if (wr_data[2]) timing_a <= wr_data; else timing_b <= wr_data;
          K_R3:  begin int_en <= wr_data[5]; dma_en <= wr_data[6]; end
          K_R4:  mode <= wr_data[6:5];
          K_R5:  reg5_q <= wr_data;
          K_CMD: begin
            case (cmd)
              C_EN:    begin dma_en <= 1'b1; pend_inc <= 1'b0; end
              C_CLRST: begin match_flg <= 1'b0; end_flg <= 1'b0; end
              C_RDSEQ: rd_restart <= 1'b1;
              C_IEN:   int_en <= 1'b1;
              C_IDIS:  int_en <= 1'b0;
              C_FRDY:  ready_lvl <= reg5_q[3];
              C_RDST:  begin rd_mask <= 8'h01; rd_restart <= 1'b1; end
              C_RST:   begin reg0_q[1:0] <= 2'b00; pend_inc <= 1'b0; int_en <= 1'b0; end
              C_LOAD: begin
                cnt_a <= addr_a; cnt_b <= addr_b; byte_cnt <= '0;
                match_flg <= 1'b0; end_flg <= 1'b0;
              end
              C_CONT: begin
                if (pend_inc) begin
                  cnt_a <= step_ctr(cnt_a, timing_a);
                  cnt_b <= step_ctr(cnt_b, timing_b);
                end
                pend_inc <= 1'b0; byte_cnt <= '0;
                match_flg <= 1'b0; end_flg <= 1'b0; dma_en <= 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_write_drops_enable: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !c_en && !c_cont && !r3_en) |=> !dma_en);
  a_r9_status_clear: assert property (@(posedge clk) disable iff (rst)
    c_clrst |=> (!match_flg && !end_flg));
  a_r10_reset_cmd: assert property (@(posedge clk) disable iff (rst)
    c_rst |=> (!int_en && reg0_q[1:0] == 2'b00));
  a_r11_load_copies: assert property (@(posedge clk) disable iff (rst)
    c_load |=> (cnt_a == $past(addr_a) && cnt_b == $past(addr_b) && byte_cnt == 16'd0));
  a_r12_continue_runs: assert property (@(posedge clk) disable iff (rst)
    c_cont |=> (dma_en && byte_cnt == 16'd0 && !match_flg && !end_flg));

endmodule

// File: tb/tb_dmaw_ctrl.sv
module tb_dmaw_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ev_byte = 1'b0, ev_stall = 1'b0, ev_match = 1'b0, ev_end = 1'b0;
  logic [15:0] addr_a, addr_b, blk_len, cnt_a, cnt_b, byte_cnt;
  logic [7:0] timing_a, timing_b, reg0_q, reg5_q, int_ctl, pulse_q, vector_q;
  logic [7:0] mask_q, match_q, rd_mask;
  logic [1:0] mode;
  logic dma_en, int_en, ready_lvl, match_flg, end_flg, rd_restart;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dmaw_ctrl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic ev(input int which);
    @(negedge clk);
    ev_byte = (which == 0); ev_stall = (which == 1);
    ev_match = (which == 2); ev_end = (which == 3);
    @(negedge clk);
    ev_byte = 1'b0; ev_stall = 1'b0; ev_match = 1'b0; ev_end = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R14 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_rst();
    // R14 reset state
    chk("R14 reset dma_en", int'(dma_en), 0);
    chk("R14 reset ready_lvl", int'(ready_lvl), 1);
    chk("R14 reset addr_a", int'(addr_a), 0);
    chk("R14 reset rd_mask", int'(rd_mask), 0);
    chk("R14 reset int_en", int'(int_en), 0);

    // R1 R4 R5 R8: exhaustive sweep of first bytes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      int e_en, e_int, e_mode;
      b = 8'(v);
      e_en = 0; e_int = 0; e_mode = 0;
      if (b[7] && b[1:0] == 2'b00) begin e_en = int'(b[6]); e_int = int'(b[5]); end
      if (b[7] && b[1:0] == 2'b11 && (b[6:2] == 5'd1 || b[6:2] == 5'd20)) e_en = 1;
      if (b[7] && b[1:0] == 2'b11 && b[6:2] == 5'd10) e_int = 1;
      if (b[7] && b[1:0] == 2'b01 && b[6:5] != 2'b11) e_mode = int'(b[6:5]);
      do_rst();
      wr(b);
      chk($sformatf("R1 sweep en %02h", b), int'(dma_en), e_en);
      chk($sformatf("R4 sweep int_en %02h", b), int'(int_en), e_int);
      chk($sformatf("R5 sweep mode %02h", b), int'(mode), e_mode);
    end
    do_rst();

    // R2 register 0 and its follow-on order
    wr(8'h79); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
    chk("R2 addr_a", int'(addr_a), 16'h1234);
    chk("R2 blk_len", int'(blk_len), 16'h5678);
    chk("R2 reg0", int'(reg0_q), 8'h79);
    wr(8'h29); wr(8'hAA); wr(8'hBB);
    chk("R2 partial addr_a", int'(addr_a), 16'h12AA);
    chk("R2 partial blk_len", int'(blk_len), 16'h56BB);

    // R5 R6 register 4, interrupt-control appends
    wr(8'h9D); wr(8'h11); wr(8'h22); wr(8'h18); wr(8'h33); wr(8'h44);
    chk("R5 addr_b", int'(addr_b), 16'h2211);
    chk("R6 int_ctl", int'(int_ctl), 8'h18);
    chk("R6 pulse", int'(pulse_q), 8'h33);
    chk("R6 vector", int'(vector_q), 8'h44);
    wr(8'h87);
    chk("R5 queue drained", int'(dma_en), 1);
    wr(8'hA1);
    chk("R5 mode 1", int'(mode), 1);
    wr(8'hFD);
    chk("R5 mode 11 ignored", int'(mode), 1);
    wr(8'h87);
    chk("R5 ignored byte queued nothing", int'(dma_en), 1);
    wr(8'h91); wr(8'h10); wr(8'h5A);
    chk("R6 vector only", int'(vector_q), 8'h5A);
    chk("R6 pulse kept", int'(pulse_q), 8'h33);

    // R3 timing bytes and dropped byte
    wr(8'hAB);
    wr(8'h44);
    chk("R3 timing_a", int'(timing_a), 8'h44);
    wr(8'h87);
    chk("R3 dropped byte no enable", int'(dma_en), 0);
    chk("R3 dropped byte int_en kept", int'(int_en), 1);
    wr(8'h87);
    chk("R3 queue empty after drop", int'(dma_en), 1);
    wr(8'h20);
    chk("R3 timing_b", int'(timing_b), 8'h20);

    // R4 register 3 mask/match
    wr(8'h98); wr(8'h0F); wr(8'hF0);
    chk("R4 mask", int'(mask_q), 8'h0F);
    chk("R4 match", int'(match_q), 8'hF0);
    chk("R4 int_en loaded 0", int'(int_en), 0);
    wr(8'hE0);
    chk("R4 en from bit6", int'(dma_en), 1);
    chk("R4 int from bit5", int'(int_en), 1);

    // R7 register 5 and force ready (R8)
    wr(8'h82); wr(8'hB3);
    chk("R7 reg5 82", int'(reg5_q), 8'h82);
    chk("R8 force ready 0", int'(ready_lvl), 0);
    wr(8'h8A); wr(8'hB3);
    chk("R8 force ready 1", int'(ready_lvl), 1);
    wr(8'hCA);
    chk("R7 bit6 ignored", int'(reg5_q), 8'h8A);
    wr(8'h86);
    chk("R7 bit2 ignored", int'(reg5_q), 8'h8A);

    // R8 other commands
    wr(8'hAF);
    chk("R8 int disable", int'(int_en), 0);
    wr(8'h87); wr(8'h83);
    chk("R8 0x83 leaves enable clear", int'(dma_en), 0);
    wr(8'hC7); wr(8'hCB);
    chk("R8 no-op ready", int'(ready_lvl), 1);
    chk("R8 no-op int", int'(int_en), 0);

    // R9 flags
    ev(2); ev(3);
    chk("R9 match set", int'(match_flg), 1);
    chk("R9 end set", int'(end_flg), 1);
    wr(8'h8B);
    chk("R9 match clear", int'(match_flg), 0);
    chk("R9 end clear", int'(end_flg), 0);

    // R11 load
    ev(0); ev(0); ev(0); ev(2);
    chk("R11 byte_cnt counted", int'(byte_cnt), 3);
    wr(8'hCF);
    chk("R11 cnt_a", int'(cnt_a), 16'h12AA);
    chk("R11 cnt_b", int'(cnt_b), 16'h2211);
    chk("R11 byte_cnt", int'(byte_cnt), 0);
    chk("R11 match clear", int'(match_flg), 0);

    // R12 continue
    wr(8'h14); wr(8'h00);
    ev(1); ev(0);
    wr(8'hD3);
    chk("R12 cnt_a up", int'(cnt_a), 16'h12AB);
    chk("R12 cnt_b down", int'(cnt_b), 16'h2210);
    chk("R12 enable", int'(dma_en), 1);
    chk("R12 byte_cnt", int'(byte_cnt), 0);
    wr(8'hD3);
    chk("R12 no pending", int'(cnt_a), 16'h12AB);
    ev(1); wr(8'h87); wr(8'hD3);
    chk("R12 0x87 cancels pending", int'(cnt_b), 16'h2210);
    wr(8'h24); ev(1); wr(8'hD3);
    chk("R12 hold code", int'(cnt_a), 16'h12AB);
    chk("R12 b still down", int'(cnt_b), 16'h220F);

    // R10 reset command
    wr(8'hAB); ev(1); wr(8'hC3);
    chk("R10 reg0 low bits", int'(reg0_q), 8'h28);
    chk("R10 int_en", int'(int_en), 0);
    wr(8'hD3);
    chk("R10 pending cleared", int'(cnt_b), 16'h220F);

    // R13 read sequence
    wr(8'hBB); wr(8'h7E);
    chk("R13 restart on mask byte", int'(rd_restart), 1);
    chk("R13 rd_mask", int'(rd_mask), 8'h7E);
    wr(8'hBF);
    chk("R13 status mask", int'(rd_mask), 8'h01);
    chk("R13 restart on 0xBF", int'(rd_restart), 1);
    wr(8'hA7);
    chk("R13 restart on 0xA7", int'(rd_restart), 1);
    chk("R13 mask kept", int'(rd_mask), 8'h01);
    @(negedge clk);
    chk("R13 restart one cycle", int'(rd_restart), 0);

    // R14 reset empties the queue
    wr(8'h79); wr(8'h01);
    do_rst();
    wr(8'h87);
    chk("R14 queue emptied", int'(dma_en), 1);
    chk("R14 addr_a cleared", int'(addr_a), 0);

    finish_run();
  end

endmodule